// File: doc/BRIEF.md
# SPI FIFO Event and Interrupt Unit

This block is the control and interrupt section of a serial peripheral interface controller. It owns a byte-wide transmit FIFO that software fills and the bit shifter drains, and a byte-wide receive FIFO that the shifter fills and software drains. Software reaches it through a small register port with four word addresses: 0 mode, 1 event/status, 2 mask and 3 data. It watches both FIFO levels against programmable thresholds, records sticky events and drives one interrupt line to the core.

The mode register holds an enable, a loopback select and two thresholds. While the block is disabled the serial side is idle. While it is enabled, the mode fields are frozen. In loopback, each byte that the shifter pops from the transmit FIFO goes straight into the receive FIFO, and the external receive input is not used.

Top module: `spi_evt_ctrl`

## Requirements
- R1: After reset the mode, event and mask registers read 0, both FIFOs are empty and irq_o is low.
- R2: Mode word layout: bit 31 is enable, bit 30 is loopback, bits 13:8 hold the transmit threshold (1 to 32) and bits 4:0 hold the receive threshold (0 to 31). All other bits read 0.
- R3: A mode write made while enable is 1 can only change the enable bit. The loopback bit and both thresholds keep their values.
- R4: Event bits sit at bit 0 (rx threshold), bit 1 (tx threshold), bit 2 (rx overflow), bit 3 (tx overflow), bit 4 (rx underflow) and bit 5 (tx underflow). Writing 1 to an event bit clears it and writing 0 leaves it alone. When a clear and a new set fall in the same cycle, the set wins.
- R5: A mask bit at 1 enables the event bit in the same position. irq_o is the OR of every event bit that is set and unmasked.
- R6: While enabled, a receive count above the receive threshold sets event bit 0 at the next clock edge. The bit stays set until it is cleared.
- R7: While enabled, a transmit count below the transmit threshold sets event bit 1 at the next clock edge. The bit stays set until it is cleared.
- R8: A read of the event address also returns live status: bit 8 is receive not empty, bit 9 is transmit not full, bits 21:16 hold the receive count and bits 29:24 hold the transmit count. Writes do not change these fields.
- R9: Each FIFO holds 32 bytes. A push into a full FIFO is dropped and sets its overflow bit. A pop from an empty FIFO is dropped and sets its underflow bit.
- R10: A write to the data address pushes wdata[7:0] into the transmit FIFO. A read of the data address returns the oldest received byte (0 if the FIFO is empty) and pops it. tx_data_o shows the oldest transmit byte.
- R11: While disabled, tx_pop_i and rx_push_i are ignored, tx_avail_o is low and the threshold events are not raised.
- R12: In loopback while enabled, each tx_pop_i pops the transmit head and pushes that byte into the receive FIFO, and rx_push_i is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe; pops the receive FIFO at the data address |
| reg_addr_i | input | 2 | Word address: 0 mode, 1 event/status, 2 mask, 3 data |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| tx_pop_i | input | 1 | Shifter takes the transmit head byte |
| tx_data_o | output | 8 | Transmit FIFO head byte |
| tx_avail_o | output | 1 | Enabled and the transmit FIFO is not empty |
| rx_push_i | input | 1 | Shifter delivers a received byte |
| rx_data_i | input | 8 | Received byte |
| irq_o | output | 1 | Interrupt to the core |

## Verification
A behavioural model built on queues runs alongside the design, and every port is compared on every clock. Directed phases come first. Thresholds are crossed from both sides with the block disabled and then enabled, so a missing enable gate shows up apart from a wrong comparison direction. Clears are issued while the condition still holds and again after it has gone, which separates set-wins behaviour from a plain clear. Both FIFOs are driven to full and to empty, with simultaneous push and pop at those edges. Loopback runs with junk on the external receive input, to show that the junk is discarded. A long pseudo-random mix of register and serial traffic then looks for ordering faults between pushes, pops, clears and mode writes.

// File: rtl/spi_evt_pkg.sv
package spi_evt_pkg;
  typedef enum logic [1:0] {
    ADDR_MODE = 2'd0,
    ADDR_EVT  = 2'd1,
    ADDR_MASK = 2'd2,
    ADDR_DATA = 2'd3
  } reg_addr_e;

  localparam int NUM_EVT   = 6;
  localparam int EV_RX_THR = 0;
  localparam int EV_TX_THR = 1;
  localparam int EV_RX_OVF = 2;
  localparam int EV_TX_OVF = 3;
  localparam int EV_RX_UDF = 4;
  localparam int EV_TX_UDF = 5;

  localparam int MODE_EN_BIT   = 31;
  localparam int MODE_LOOP_BIT = 30;
  localparam int TXTHR_LSB     = 8;
  localparam int TXTHR_W       = 6;
  localparam int RXTHR_LSB     = 0;
  localparam int RXTHR_W       = 5;

  localparam int ST_RXNE_BIT = 8;
  localparam int ST_TXNF_BIT = 9;
  localparam int RXCNT_LSB   = 16;
  localparam int TXCNT_LSB   = 24;

  typedef struct packed {
    logic               en;
    logic               loop;
    logic [TXTHR_W-1:0] txthr;
    logic [RXTHR_W-1:0] rxthr;
  } mode_t;
endpackage

// File: rtl/spi_evt_fifo.sv
module spi_evt_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 32,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] cnt_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  // acceptance judged on the count before this cycle
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign head_o  = mem_q[rd_q];
  assign cnt_o   = cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= nxt(wr_q);
      if (pop_ok)  rd_q <= nxt(rd_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/spi_evt_mode.sv
module spi_evt_mode
  import spi_evt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  output mode_t       mode_o,
  output logic [31:0] rd_o
);
  mode_t mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
    end else if (we_i) begin
      mode_q.en <= wdata_i[MODE_EN_BIT];
      if (!mode_q.en) begin  // fields frozen while running
        mode_q.loop  <= wdata_i[MODE_LOOP_BIT];
        mode_q.txthr <= wdata_i[TXTHR_LSB +: TXTHR_W];
        mode_q.rxthr <= wdata_i[RXTHR_LSB +: RXTHR_W];
      end
    end
  end

  always_comb begin
    rd_o                          = '0;
    rd_o[MODE_EN_BIT]             = mode_q.en;
    rd_o[MODE_LOOP_BIT]           = mode_q.loop;
    rd_o[TXTHR_LSB +: TXTHR_W]    = mode_q.txthr;
    rd_o[RXTHR_LSB +: RXTHR_W]    = mode_q.rxthr;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/spi_evt_events.sv
module spi_evt_events #(
  parameter int N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_i,
  input  logic         mask_we_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] evt_o,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);
  logic [N-1:0] evt_q, mask_q;

  for (genvar i = 0; i < N; i++) begin : g_evt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    evt_q[i] <= 1'b0;
      else if (set_i[i])              evt_q[i] <= 1'b1;  // set beats clear
      else if (clr_we_i && clr_i[i])  evt_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '0;
    else if (mask_we_i) mask_q <= mask_i;
  end

  assign evt_o  = evt_q;
  assign mask_o = mask_q;
  assign irq_o  = |(evt_q & mask_q);
endmodule

// File: rtl/spi_evt_ctrl.sv
module spi_evt_ctrl
  import spi_evt_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 32,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic          reg_re_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  input  logic          tx_pop_i,
  output logic [DW-1:0] tx_data_o,
  output logic          tx_avail_o,
  input  logic          rx_push_i,
  input  logic [DW-1:0] rx_data_i,
  output logic          irq_o
);
  reg_addr_e     addr;
  mode_t         mode;
  logic [31:0]   mode_rd;
  logic          wr_mode, wr_evt, wr_mask, wr_data, rd_data;
  logic [DW-1:0] tx_head, rx_head, rx_in;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic          tx_pop, rx_push;
  logic [NUM_EVT-1:0] evt_set, evt, mask;

  assign addr    = reg_addr_e'(reg_addr_i);
  assign wr_mode = reg_we_i && addr == ADDR_MODE;
  assign wr_evt  = reg_we_i && addr == ADDR_EVT;
  assign wr_mask = reg_we_i && addr == ADDR_MASK;
  assign wr_data = reg_we_i && addr == ADDR_DATA;
  assign rd_data = reg_re_i && addr == ADDR_DATA;

  spi_evt_mode u_mode (
    .clk_i, .rst_ni,
    .we_i    (wr_mode),
    .wdata_i (reg_wdata_i),
    .mode_o  (mode),
    .rd_o    (mode_rd)
  );

  assign tx_pop  = mode.en && tx_pop_i;
  assign rx_push = mode.en && (mode.loop ? (tx_pop && !tx_empty) : rx_push_i);
  assign rx_in   = mode.loop ? tx_head : rx_data_i;

  spi_evt_fifo #(.DW(DW), .DEPTH(DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni,
    .push_i  (wr_data),
    .data_i  (reg_wdata_i[DW-1:0]),
    .pop_i   (tx_pop),
    .head_o  (tx_head),
    .cnt_o   (tx_cnt),
    .full_o  (tx_full),
    .empty_o (tx_empty)
  );

  spi_evt_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni,
    .push_i  (rx_push),
    .data_i  (rx_in),
    .pop_i   (rd_data),
    .head_o  (rx_head),
    .cnt_o   (rx_cnt),
    .full_o  (rx_full),
    .empty_o (rx_empty)
  );

  always_comb begin
    evt_set            = '0;
    evt_set[EV_RX_THR] = mode.en && (rx_cnt > CW'(mode.rxthr));
    evt_set[EV_TX_THR] = mode.en && (tx_cnt < CW'(mode.txthr));
    evt_set[EV_RX_OVF] = rx_push && rx_full;
    evt_set[EV_TX_OVF] = wr_data && tx_full;
    evt_set[EV_RX_UDF] = rd_data && rx_empty;
    evt_set[EV_TX_UDF] = tx_pop && tx_empty;
  end

  spi_evt_events #(.N(NUM_EVT)) u_events (
    .clk_i, .rst_ni,
    .set_i     (evt_set),
    .clr_we_i  (wr_evt),
    .clr_i     (reg_wdata_i[NUM_EVT-1:0]),
    .mask_we_i (wr_mask),
    .mask_i    (reg_wdata_i[NUM_EVT-1:0]),
    .evt_o     (evt),
    .mask_o    (mask),
    .irq_o     (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (addr)
      ADDR_MODE: reg_rdata_o = mode_rd;
      ADDR_EVT: begin
        reg_rdata_o[NUM_EVT-1:0]     = evt;
        reg_rdata_o[ST_RXNE_BIT]     = !rx_empty;
        reg_rdata_o[ST_TXNF_BIT]     = !tx_full;
        reg_rdata_o[RXCNT_LSB +: CW] = rx_cnt;
        reg_rdata_o[TXCNT_LSB +: CW] = tx_cnt;
      end
      ADDR_MASK: reg_rdata_o[NUM_EVT-1:0] = mask;
      ADDR_DATA: reg_rdata_o[DW-1:0] = rx_empty ? '0 : rx_head;
      default:   reg_rdata_o = '0;
    endcase
  end

  assign tx_data_o  = tx_head;
  assign tx_avail_o = mode.en && !tx_empty;
endmodule

// File: rtl/spi_evt_ctrl_chk.sv
module spi_evt_ctrl_chk
  import spi_evt_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CW    = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               reg_we_i,
  input logic               reg_re_i,
  input logic [1:0]         reg_addr_i,
  input logic [31:0]        reg_wdata_i,
  input logic               tx_pop_i,
  input mode_t              mode,
  input logic [NUM_EVT-1:0] evt,
  input logic [CW-1:0]      rx_cnt,
  input logic [CW-1:0]      tx_cnt
);
  a_r3_mode_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode.en && reg_we_i && reg_addr_i == ADDR_MODE)
    |=> ($stable(mode.loop) && $stable(mode.txthr) && $stable(mode.rxthr)));

  a_r6_rx_thr_raise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode.en && rx_cnt > CW'(mode.rxthr)) |=> evt[EV_RX_THR]);

  a_r7_tx_thr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt[EV_TX_THR] && !(reg_we_i && reg_addr_i == ADDR_EVT && reg_wdata_i[EV_TX_THR]))
    |=> evt[EV_TX_THR]);

  a_r9_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_cnt <= CW'(DEPTH)) && (tx_cnt <= CW'(DEPTH)));

  a_r11_idle_tx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode.en && !(reg_we_i && reg_addr_i == ADDR_DATA)) |=> $stable(tx_cnt));

  a_r12_loop_ext_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode.en && mode.loop && !tx_pop_i && !(reg_re_i && reg_addr_i == ADDR_DATA))
    |=> $stable(rx_cnt));
endmodule

bind spi_evt_ctrl spi_evt_ctrl_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_re_i    (reg_re_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .tx_pop_i    (tx_pop_i),
  .mode        (mode),
  .evt         (evt),
  .rx_cnt      (rx_cnt),
  .tx_cnt      (tx_cnt)
);

// File: tb/spi_evt_ctrl_bench.sv
module spi_evt_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0, txpop = 1'b0, rxpush = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [7:0]  rxdata = '0;
  logic [31:0] rdata;
  logic [7:0]  txdata;
  logic        txavail, irq;

  int errors = 0, checks = 0;
  bit done = 0;

  // reference state
  bit        m_en, m_loop;
  int        m_txthr, m_rxthr;
  bit [5:0]  m_evt, m_mask;
  byte unsigned txq[$], rxq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_evt_ctrl u_spi_evt_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata),
    .tx_pop_i(txpop), .tx_data_o(txdata), .tx_avail_o(txavail),
    .rx_push_i(rxpush), .rx_data_i(rxdata),
    .irq_o(irq)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rdata();
    logic [31:0] v = '0;
    case (addr)
      2'd0: begin v[31] = m_en; v[30] = m_loop; v[13:8] = 6'(m_txthr); v[4:0] = 5'(m_rxthr); end
      2'd1: begin
        v[5:0] = m_evt; v[8] = rxq.size() > 0; v[9] = txq.size() < DEPTH;
        v[21:16] = 6'(rxq.size()); v[29:24] = 6'(txq.size());
      end
      2'd2: v[5:0] = m_mask;
      default: v[7:0] = (rxq.size() > 0) ? rxq[0] : 8'h00;
    endcase
    return v;
  endfunction

  task automatic model_edge();
    int rxn = rxq.size(), txn = txq.size();
    byte unsigned lb = 0;
    bit lb_ok = 0;
    bit [5:0] set = '0;
    if (m_en && rxn > m_rxthr) set[0] = 1;
    if (m_en && txn < m_txthr) set[1] = 1;
    if (m_en && txpop) begin
      if (txn > 0) begin lb = txq.pop_front(); lb_ok = 1; end else set[5] = 1;
    end
    if (we && addr == 2'd3) begin
      if (txn < DEPTH) txq.push_back(wdata[7:0]); else set[3] = 1;
    end
    if (re && addr == 2'd3) begin
      if (rxn > 0) void'(rxq.pop_front()); else set[4] = 1;
    end
    if (m_en && (m_loop ? lb_ok : rxpush)) begin
      if (rxn < DEPTH) rxq.push_back(m_loop ? lb : rxdata); else set[2] = 1;
    end
    m_evt = (m_evt & ~((we && addr == 2'd1) ? wdata[5:0] : 6'd0)) | set;
    if (we && addr == 2'd2) m_mask = wdata[5:0];
    if (we && addr == 2'd0) begin
      if (m_en) m_en = wdata[31];
      else begin
        m_en = wdata[31]; m_loop = wdata[30];
        m_txthr = int'(wdata[13:8]); m_rxthr = int'(wdata[4:0]);
      end
    end
  endtask

  // one clock: inputs already driven after negedge; compare, then advance
  task automatic step(string tag);
    #1;
    chk(tag, "rdata", rdata, exp_rdata());
    chk(tag, "irq", 32'(irq), 32'(|(m_evt & m_mask)));
    chk(tag, "tx_avail", 32'(txavail), 32'(m_en && txq.size() > 0));
    if (txq.size() > 0) chk(tag, "tx_data", 32'(txdata), 32'(txq[0]));
    @(posedge clk);
    model_edge();
    @(negedge clk);
    we = 0; re = 0; txpop = 0; rxpush = 0;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d, string tag);
    addr = a; wdata = d; we = 1; step(tag);
  endtask
  task automatic rd(logic [1:0] a, string tag);
    addr = a; re = 1; step(tag);
  endtask
  task automatic ser(bit p, bit s, logic [7:0] d, string tag);
    addr = 2'd1; txpop = p; rxpush = s; rxdata = d; step(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    // R1: reset state of all registers, FIFOs and irq
    for (int a = 0; a < 4; a++) begin addr = 2'(a); step("R1"); end
    // R2: layout, reserved bits dropped
    wr(2'd0, 32'h20FF_C4E2 & ~32'h8000_0000 | 32'h0000_0400, "R2");
    wr(2'd0, 32'h00FF_0402, "R2");
    addr = 2'd0; step("R2");
    // R11: disabled serial side ignored, no threshold events
    wr(2'd3, 32'h11, "R10"); wr(2'd3, 32'h22, "R10");
    ser(1, 1, 8'hA5, "R11"); ser(1, 0, 8'h00, "R11");
    addr = 2'd1; step("R11");
    // R5/R7: enable with mask 0, tx below threshold
    wr(2'd0, 32'h8000_0402, "R7");
    addr = 2'd1; step("R7"); step("R5");
    wr(2'd2, 32'h02, "R5"); addr = 2'd0; step("R5");
    // R3: locked fields
    wr(2'd0, 32'hC000_0A1F, "R3"); addr = 2'd0; step("R3");
    // R4: write 0 no effect, clear while condition holds
    wr(2'd1, 32'h0, "R4"); wr(2'd1, 32'h2, "R4"); addr = 2'd1; step("R4");
    for (int i = 0; i < 3; i++) wr(2'd3, 32'(8'h30 + i), "R10");
    addr = 2'd1; step("R7");
    wr(2'd1, 32'h3F, "R4"); addr = 2'd1; step("R4"); step("R4");
    // R10/R9: drain tx then underflow
    wr(2'd2, 32'h3F, "R5");
    for (int i = 0; i < 6; i++) ser(1, 0, 8'h00, "R10");
    ser(1, 0, 8'h00, "R9");
    // R6/R8: external receive, status unaffected by writes
    for (int i = 0; i < 3; i++) ser(0, 1, 8'(8'h50 + i), "R6");
    addr = 2'd1; step("R6");
    wr(2'd1, 32'hFFFF_FFC0, "R8"); addr = 2'd1; step("R8");
    for (int i = 0; i < 4; i++) rd(2'd3, "R10");
    addr = 2'd1; step("R9");
    // R9: tx overflow then rx overflow
    for (int i = 0; i < 33; i++) wr(2'd3, 32'(i * 7), "R9");
    addr = 2'd1; step("R9");
    for (int i = 0; i < 34; i++) ser(0, 1, 8'(i), "R9");
    addr = 2'd1; step("R9");
    // R12: loopback
    wr(2'd0, 32'h0, "R3"); wr(2'd0, 32'hC000_0402, "R12");
    for (int i = 0; i < 33; i++) rd(2'd3, "R10");
    for (int i = 0; i < 5; i++) ser(1, 1, 8'hEE, "R12");
    ser(0, 1, 8'hEE, "R12");
    for (int i = 0; i < 6; i++) rd(2'd3, "R12");
    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      int unsigned r = $urandom();
      addr = 2'(r[1:0]);
      we = (r[4:2] == 3'd0) || (r[4:2] == 3'd1 && addr != 2'd0);
      re = r[5];
      wdata = {r[31:30], 16'h0, r[13:8] % 6'd33, 3'b0, r[29:25]} | 32'(r[7:6] << 30);
      if (addr != 2'd0) wdata = $urandom();
      txpop = r[14]; rxpush = r[15]; rxdata = 8'(r >> 16);
      step("R10");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule